// File: doc/BRIEF.md
# Shift-Chain Upset Test Controller

This block drives a long serial chain of registers under test and counts the bits that come back wrong. A 16-bit maximal-length LFSR produces the stimulus bits that go into the chain. A second LFSR with the same seed produces the expected bits, running a full chain length behind the first. Each returned bit that differs from its expected value adds one to a saturating error counter. The counter clears when a new test starts.

The block has two test modes, chosen at start. In static mode it streams one chain-length of pattern into the chain and then holds the shift enable low for a hold interval. The interval is either a programmed cycle count or lasts until an external release pulse. The block then shifts the chain contents out, compares every bit and raises done. In dynamic mode it shifts without pause. The chain is filled once, then every later shift both loads a new bit and checks a returned bit. A stop request ends the run at the next whole-chain boundary.

Top module: `shift_upset_tester`

## Requirements
- R1: After reset, chain_en_o is 0, done_o is 0 and err_cnt_o is 0.
- R2: A start_i pulse sampled while the block is idle or done clears err_cnt_o in that same edge and begins a load phase of exactly CHAIN_LEN cycles with chain_en_o high. In the load phase chain_si_o gives the sequence s[15] of an LFSR seeded with seed_i, where the next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}. A seed_i of 0 is replaced by 16'h0001.
- R3: In static mode (mode_dyn_i=0) with hold_ext_i=0, chain_en_o stays low after the load for exactly hold_cycles_i+1 cycles.
- R4: In static mode with hold_ext_i=1, the hold lasts until release_i is sampled high. chain_en_o rises in the cycle after that edge and stays low until then, whatever the hold count.
- R5: In static mode the readback is CHAIN_LEN shift cycles, each comparing chain_so_i with the expected sequence. err_cnt_o then equals the number of corrupted chain cells, and done_o is 1 from the end of the readback until the next start.
- R6: In dynamic mode (mode_dyn_i=1), chain_en_o stays high with no gap, and no comparison takes place during the first CHAIN_LEN shifts.
- R7: In dynamic mode, every shift after the first CHAIN_LEN compares chain_so_i with the expected bit, and each mismatch adds one to err_cnt_o.
- R8: A stop_i pulse in dynamic mode ends the run when the shift count reaches the next whole multiple of CHAIN_LEN (at least 2*CHAIN_LEN), after which done_o is 1 and chain_en_o is 0.
- R9: err_cnt_o saturates at 2^ERR_W-1 and does not wrap.
- R10: start_i is ignored while a test is running, and the error count and the run carry on.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a test (idle or done only) |
| mode_dyn_i | input | 1 | Test mode sampled at start: 0 static, 1 dynamic |
| stop_i | input | 1 | End a dynamic run at the next chain boundary |
| seed_i | input | 16 | LFSR seed, loaded at start |
| hold_cycles_i | input | HOLD_W (32) | Static hold length in cycles |
| hold_ext_i | input | 1 | 1: the hold lasts until release_i |
| release_i | input | 1 | Ends an externally timed hold |
| chain_so_i | input | 1 | Serial data returning from the chain |
| chain_si_o | output | 1 | Serial data into the chain |
| chain_en_o | output | 1 | Chain shift enable |
| err_cnt_o | output | ERR_W (32) | Saturating mismatch count |
| done_o | output | 1 | Test finished |

## Verification
On every cycle the assertions check that the error count never drops except at a start, never moves by more than one in a cycle and holds once it is full. They also check that every load ends on the last chain position before a hold begins, and that each run finishes on a chain boundary. Only the bench scenarios can show the rest. This covers the stimulus sequence itself, the error count after cells are flipped during a hold, and the exact hold length in cycles. It also covers the release-pulse timing, the absence of checking while a dynamic run is filling, and an ignored start in mid-run.

// File: rtl/shift_upset_pkg.sv
// Shared types for the shift-chain upset tester.
// Assumes: one clock domain; users import the whole package.
package shift_upset_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_HOLD,
        ST_READ,
        ST_RUN,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/sut_lfsr.sv
// Fibonacci LFSR that shifts left and outputs its top bit.
// Assumes: TAPS describes a maximal-length polynomial; a zero seed
// would lock up, so it is replaced with 1 when loaded.
module sut_lfsr #(
    parameter int          W    = 16,
    parameter logic [15:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    input  logic         adv_i,
    output logic         bit_o
);
    logic [W-1:0] state_q;
    logic         fb;

    // feedback is the parity of the tapped bits
    always_comb fb = ^(state_q & TAPS[W-1:0]);

    // reseed on load, advance by one step on adv
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= {{(W-1){1'b0}}, 1'b1};
        else if (load_i)
            state_q <= (seed_i == '0) ? {{(W-1){1'b0}}, 1'b1} : seed_i;
        else if (adv_i)
            state_q <= {state_q[W-2:0], fb};
    end

    assign bit_o = state_q[W-1];
endmodule

// File: rtl/sut_err_counter.sv
// Saturating mismatch counter, cleared synchronously at a test start.
// Assumes: inc_i and clear_i are single-cycle qualifiers; clear wins.
module sut_err_counter #(
    parameter int ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [ERR_W-1:0] cnt_o
);
    localparam logic [ERR_W-1:0] MAXV = '1;

    // count up on mismatch, hold at the top value
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (clear_i)
            cnt_o <= '0;
        else if (inc_i && cnt_o != MAXV)
            cnt_o <= cnt_o + 1'b1;
    end

    // R9: a full counter stays full until cleared
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_o) == MAXV && !$past(clear_i)) |-> cnt_o == MAXV);
    // R7: without a clear the count never decreases
    a_r7_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear_i) |-> cnt_o >= $past(cnt_o));
    // R7: at most one per cycle
    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear_i) |-> (cnt_o - $past(cnt_o)) <= 1);
endmodule

// File: rtl/sut_sequencer.sv
// Phase sequencer: load, hold, readback for the static test, and
// load then continuous run for the dynamic test.
// Assumes: CHAIN_LEN >= 2; hold inputs are read live during the hold.
module sut_sequencer
    import shift_upset_pkg::*;
#(
    parameter int CHAIN_LEN = 1024,
    parameter int HOLD_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_dyn_i,
    input  logic              stop_i,
    input  logic [HOLD_W-1:0] hold_cycles_i,
    input  logic              hold_ext_i,
    input  logic              release_i,
    output logic              begin_o,
    output logic              gen_adv_o,
    output logic              chk_adv_o,
    output logic              chain_en_o,
    output logic              done_o
);
    localparam int             POS_W = $clog2(CHAIN_LEN);
    localparam logic [POS_W-1:0] LAST = POS_W'(CHAIN_LEN - 1);

    seq_state_t        state_q;
    logic [POS_W-1:0]  pos_q;
    logic [HOLD_W-1:0] hcnt_q;
    logic              dyn_q;
    logic              stop_pend_q;
    logic              idle_like;
    logic              hold_over;

    // start is honoured only when no test is running
    always_comb idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
    // the hold ends on the release pulse or the programmed count
    always_comb hold_over = hold_ext_i ? release_i : (hcnt_q == hold_cycles_i);

    // phase state, chain position and hold timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pos_q       <= '0;
            hcnt_q      <= '0;
            dyn_q       <= 1'b0;
            stop_pend_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start_i) begin
                        state_q     <= ST_LOAD;
                        pos_q       <= '0;
                        dyn_q       <= mode_dyn_i;
                        stop_pend_q <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    if (dyn_q && stop_i) stop_pend_q <= 1'b1;
                    if (pos_q == LAST) begin
                        pos_q   <= '0;
                        hcnt_q  <= '0;
                        state_q <= dyn_q ? ST_RUN : ST_HOLD;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (hold_over) state_q <= ST_READ;
                    else           hcnt_q  <= hcnt_q + 1'b1;
                end
                ST_READ: begin
                    if (pos_q == LAST) state_q <= ST_DONE;
                    else               pos_q   <= pos_q + 1'b1;
                end
                ST_RUN: begin
                    if (stop_i) stop_pend_q <= 1'b1;
                    if (pos_q == LAST) begin
                        pos_q <= '0;
                        if (stop_pend_q || stop_i) state_q <= ST_DONE;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // per-phase controls for the generators, comparator and chain
    always_comb begin
        begin_o    = idle_like && start_i;
        gen_adv_o  = (state_q == ST_LOAD) || (state_q == ST_RUN);
        chk_adv_o  = (state_q == ST_READ) || (state_q == ST_RUN);
        chain_en_o = gen_adv_o || (state_q == ST_READ);
        done_o     = (state_q == ST_DONE);
    end

    // R3: a hold is entered only from the final load position
    a_r3_hold_after_full_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q) == ST_LOAD) |-> $past(pos_q) == LAST);
    // R8, R5: every run finishes on a chain boundary
    a_r8_done_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(pos_q) == LAST);
    // R6: no checking while a dynamic run is filling
    a_r6_no_check_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> !chk_adv_o);
endmodule

// File: rtl/shift_upset_tester.sv
// Top of the shift-chain upset tester: a stimulus LFSR feeds the chain,
// a matching LFSR one chain-length behind predicts the returned bits,
// and mismatches are counted.
// Assumes: the chain shifts once per cycle while chain_en_o is high and
// chain_so_i shows the oldest cell combinationally.
module shift_upset_tester
    import shift_upset_pkg::*;
#(
    parameter int CHAIN_LEN = 1024,
    parameter int HOLD_W    = 32,
    parameter int ERR_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_dyn_i,
    input  logic              stop_i,
    input  logic [15:0]       seed_i,
    input  logic [HOLD_W-1:0] hold_cycles_i,
    input  logic              hold_ext_i,
    input  logic              release_i,
    input  logic              chain_so_i,
    output logic              chain_si_o,
    output logic              chain_en_o,
    output logic [ERR_W-1:0]  err_cnt_o,
    output logic              done_o
);
    logic begin_w, gen_adv, chk_adv, exp_bit, mismatch;

    sut_sequencer #(.CHAIN_LEN(CHAIN_LEN), .HOLD_W(HOLD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_dyn_i(mode_dyn_i),
        .stop_i(stop_i), .hold_cycles_i(hold_cycles_i), .hold_ext_i(hold_ext_i),
        .release_i(release_i), .begin_o(begin_w), .gen_adv_o(gen_adv),
        .chk_adv_o(chk_adv), .chain_en_o(chain_en_o), .done_o(done_o)
    );

    sut_lfsr #(.W(16)) u_gen (
        .clk(clk), .rst_n(rst_n), .load_i(begin_w), .seed_i(seed_i),
        .adv_i(gen_adv), .bit_o(chain_si_o)
    );

    sut_lfsr #(.W(16)) u_chk (
        .clk(clk), .rst_n(rst_n), .load_i(begin_w), .seed_i(seed_i),
        .adv_i(chk_adv), .bit_o(exp_bit)
    );

    // compare only on shifts that return loaded data
    always_comb mismatch = chk_adv && (chain_so_i != exp_bit);

    sut_err_counter #(.ERR_W(ERR_W)) u_err (
        .clk(clk), .rst_n(rst_n), .clear_i(begin_w), .inc_i(mismatch),
        .cnt_o(err_cnt_o)
    );

    // R2: a start always leaves a zero count behind it
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(begin_w) |-> err_cnt_o == '0);
endmodule

// File: tb/test_shift_upset_tester.sv
module test_shift_upset_tester;
    localparam int L  = 32;
    localparam int EW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, mode_dyn_i = 0, stop_i = 0, hold_ext_i = 0, release_i = 0;
    logic [15:0] seed_i = 16'h1;
    logic [31:0] hold_cycles_i = 0;
    logic chain_si_o, chain_en_o, done_o, chain_so_i;
    logic [EW-1:0] err_cnt_o;

    logic [L-1:0] chain = '0;
    logic [L-1:0] flip_mask = '0;
    logic flip_req = 0, inv_so = 0;

    int total = 0, bad = 0;

    always #10 clk = ~clk;

    shift_upset_tester #(.CHAIN_LEN(L), .HOLD_W(32), .ERR_W(EW)) i_shift_upset_tester (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_dyn_i(mode_dyn_i),
        .stop_i(stop_i), .seed_i(seed_i), .hold_cycles_i(hold_cycles_i),
        .hold_ext_i(hold_ext_i), .release_i(release_i), .chain_so_i(chain_so_i),
        .chain_si_o(chain_si_o), .chain_en_o(chain_en_o), .err_cnt_o(err_cnt_o),
        .done_o(done_o)
    );

    // chain model: shifts on enable, cells can be flipped while frozen
    always_ff @(posedge clk) begin
        if (chain_en_o)    chain <= {chain[L-2:0], chain_si_o};
        else if (flip_req) chain <= chain ^ flip_mask;
    end
    assign chain_so_i = chain[L-1] ^ inv_so;

    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_start(input logic dyn, input logic [15:0] sd,
                            input logic [31:0] hold, input logic ext);
        mode_dyn_i = dyn; seed_i = sd; hold_cycles_i = hold; hold_ext_i = ext;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
    endtask

    // {seed, hold cycles, cells flipped during the hold}
    localparam logic [47:0] TBL [5] = '{
        {16'hACE1, 16'd3,  16'd0},
        {16'h1234, 16'd0,  16'd1},
        {16'h00FF, 16'd10, 16'd5},
        {16'hBEEF, 16'd1,  16'd10},
        {16'h0000, 16'd2,  16'd3}
    };

    task automatic run_static(input logic [15:0] sd, input int hold, input int nf);
        logic [15:0] ref_s;
        int si_bad, low;
        ref_s = (sd == 0) ? 16'h0001 : sd;
        si_bad = 0; low = 0;
        do_start(1'b0, sd, 32'(hold), 1'b0);
        check(err_cnt_o == 0, "R2 count cleared at start", int'(err_cnt_o), 0);
        while (chain_en_o) begin
            if (chain_si_o != ref_s[15]) si_bad++;
            ref_s = nxt(ref_s);
            @(negedge clk);
        end
        check(si_bad == 0, "R2 stimulus sequence", si_bad, 0);
        flip_mask = '0;
        for (int i = 0; i < nf; i++) flip_mask[3*i] = 1'b1;
        flip_req = 1;
        while (!chain_en_o && low < 1000) begin
            low++;
            @(negedge clk);
            flip_req = 0;
        end
        check(low == hold + 1, "R3 hold length", low, hold + 1);
        while (chain_en_o) @(negedge clk);
        check(done_o == 1, "R5 done after readback", int'(done_o), 1);
        check(int'(err_cnt_o) == nf, "R5 static upset count", int'(err_cnt_o), nf);
    endtask

    // dynamic run: inv windows are shift numbers, stop pulse at shift stop_at
    task automatic run_dyn(input int inv_a, input int inv_b, input int inv_c, input int inv_d,
                           input int stop_at, input int start_at, input int exp_err,
                           input string tag);
        int n, gaps, exp_total;
        n = 0; gaps = 0;
        do_start(1'b1, 16'h5A5A, 32'd0, 1'b0);
        while (!done_o && n < 20*L) begin
            if (chain_en_o) n++; else gaps++;
            inv_so  = ((n >= inv_a && n <= inv_b) || (n >= inv_c && n <= inv_d)) ? 1'b1 : 1'b0;
            stop_i  = (n == stop_at);
            start_i = (n == start_at);
            @(negedge clk);
        end
        inv_so = 0; stop_i = 0; start_i = 0;
        exp_total = (stop_at <= L) ? 2*L : ((stop_at + L - 1) / L) * L;
        check(gaps == 0, "R6 continuous shifting", gaps, 0);
        check(n == exp_total, "R8 stop at chain boundary", n, exp_total);
        check(done_o == 1 && chain_en_o == 0, "R8 done after stop", int'(done_o), 1);
        check(int'(err_cnt_o) == exp_err, tag, int'(err_cnt_o), exp_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(chain_en_o == 0, "R1 enable low in reset", int'(chain_en_o), 0);
        check(done_o == 0, "R1 done low in reset", int'(done_o), 0);
        check(err_cnt_o == 0, "R1 count zero in reset", int'(err_cnt_o), 0);
        rst_n = 1;
        @(negedge clk);
        check(chain_en_o == 0 && done_o == 0, "R1 idle after reset", int'(chain_en_o), 0);

        // R3, R5 static table (last row also covers the zero seed of R2)
        for (int r = 0; r < 5; r++)
            run_static(TBL[r][47:32], int'(TBL[r][31:16]), int'(TBL[r][15:0]));
        repeat (3) @(negedge clk);
        check(done_o == 1, "R5 done held until start", int'(done_o), 1);

        // R4 externally released hold, count of 0 must not end it
        do_start(1'b0, 16'h7777, 32'd0, 1'b1);
        while (chain_en_o) @(negedge clk);
        repeat (20) @(negedge clk);
        check(chain_en_o == 0, "R4 hold waits for release", int'(chain_en_o), 0);
        release_i = 1;
        @(negedge clk);
        release_i = 0;
        check(chain_en_o == 1, "R4 readback after release", int'(chain_en_o), 1);
        while (chain_en_o) @(negedge clk);
        check(err_cnt_o == 0 && done_o == 1, "R4 clean readback", int'(err_cnt_o), 0);

        // R6, R7: load-phase corruption ignored, 5 run-phase errors counted
        run_dyn(1, L, L+3, L+7, L+10, -1, 5, "R7 dynamic mismatch count");
        // R8 stop during load ends after first compare pass
        run_dyn(-1, -1, -1, -1, 5, -1, 0, "R6 clean dynamic run");
        // R10 start mid-run ignored
        run_dyn(L+1, L+4, -1, -1, L+8, L+8, 4, "R10 start ignored while running");
        // R9 saturation: every compare wrong for three passes
        run_dyn(1, 10*L, -1, -1, 3*L+5, -1, (1<<EW)-1, "R9 saturating count");

        // R2 new start clears the saturated count
        do_start(1'b0, 16'h0F0F, 32'd1, 1'b0);
        check(err_cnt_o == 0, "R2 clear after saturation", int'(err_cnt_o), 0);
        while (!done_o) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule